// File: doc/BRIEF.md
# Descriptor Ring Dispatch Controller

This block is the control side of a bus master engine that works from a circular ring of command descriptors in memory. Software programs three things through a 32-bit register port: where the ring lives, how many entries it has, and how far its own producer index has advanced. It then sets a run bit. The block owns a consumer index (the tail). Whenever the run bit is set and the tail has not caught up with the software index (the head), it hands the descriptor at the tail to an external sequencer. It does this with a one-cycle start pulse and waits for the matching done. The pulse carries the descriptor index and its byte address in memory.

Each time a descriptor finishes, the tail moves forward one entry and wraps to zero after the last one. If the finished descriptor asked for an interrupt, a completion status bit is set. If it failed while error interrupts are enabled, an error status bit is set. Software clears either bit by writing one to it, and the interrupt line is high while either bit is set. The block also holds a two-bit bus speed selection for the bus sequencer, along with a retry policy word that software can read back.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset, the control word, status word, ring size and tail read as zero, and `busy`, `irq` and `seq_start` are low.
- R2: These registers read back what was written: ring base low at 0x100, ring base high at 0x104, control at 0x108 (bit 0 run, bit 4 error interrupt enable, bits 23:16 head; other bits read zero), ring size at 0x110 (bits 7:0 = entries minus one) and retry policy at 0x114 (all 32 bits).
- R3: While run is set and tail differs from head, the block pulses `seq_start` for exactly one cycle with `seq_index` equal to the tail. `busy` is high from that pulse until the cycle after `seq_done`.
- R4: `seq_addr` equals the 64-bit ring base plus sixteen times the tail index being issued.
- R5: Each accepted `seq_done` advances the tail by one. A tail equal to the ring size field wraps to zero. The tail changes at no other time.
- R6: Dispatch stops once tail equals head; `busy` then stays low and no further `seq_start` occurs.
- R7: Clearing run while a descriptor is in flight lets that descriptor complete and advance the tail, but no further descriptor is started.
- R8: Status bit 5 (completion) is set when a descriptor finishes with `seq_irq_req` high, and is not set when that input is low.
- R9: Status bit 4 (error) is set when a descriptor finishes with `seq_ok` low while control bit 4 is one, and is not set while control bit 4 is zero.
- R10: Writing one to status bit 4 or bit 5 at 0x10C clears that bit, and writing zero leaves it unchanged. `irq` is high exactly while either bit is set.
- R11: Status reads return `busy` in bit 0 and the tail in bits 23:16.
- R12: Bits 31:30 of the timing register at 0x300 drive `bus_speed` and read back in place, with 0 = 80 kHz, 1 = 100 kHz, 2 = 400 kHz and 3 = 1 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on `reg_rdata` one cycle later |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| seq_start | output | 1 | One-cycle pulse issuing a descriptor |
| seq_index | output | 8 | Ring index of the issued descriptor |
| seq_addr | output | 64 | Memory byte address of the issued descriptor |
| seq_done | input | 1 | Sequencer finished the issued descriptor |
| seq_ok | input | 1 | Finished descriptor succeeded (valid with `seq_done`) |
| seq_irq_req | input | 1 | Finished descriptor requested a completion interrupt (valid with `seq_done`) |
| busy | output | 1 | A descriptor is in flight |
| irq | output | 1 | Completion or error status pending |
| bus_speed | output | 2 | Bus speed selection |

## Verification
The bench targets the wrap of the tail from the last ring entry back to zero. A design that wraps on entries rather than entries minus one issues an out-of-ring index and an address past the ring. It also checks that a dispatch stops exactly when the tail meets the head; an off-by-one there would issue an extra descriptor and show up in the count of start pulses. Clearing run with a descriptor in flight must still advance the tail without issuing anything more. The status register is written with zero to catch a clear-on-any-write bug, and an error completion with the enable off must leave `irq` low.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_BASE_LO = 12'h100;
  localparam logic [REG_AW-1:0] OFS_BASE_HI = 12'h104;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 12'h108;
  localparam logic [REG_AW-1:0] OFS_STATUS  = 12'h10C;
  localparam logic [REG_AW-1:0] OFS_SIZE    = 12'h110;
  localparam logic [REG_AW-1:0] OFS_RETRY   = 12'h114;
  localparam logic [REG_AW-1:0] OFS_TIMING  = 12'h300;

  localparam int BIT_RUN     = 0;
  localparam int BIT_ERR_IE  = 4;
  localparam int BIT_BUSY    = 0;
  localparam int BIT_ERR_STS = 4;
  localparam int BIT_CMP_STS = 5;
  localparam int PTR_LSB     = 16;
  localparam int SPD_LSB     = 30;

  typedef enum logic [0:0] {ST_IDLE, ST_WAIT} disp_state_t;
endpackage

// File: rtl/ring_regs.sv
module ring_regs
  import ring_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int BASE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output logic [BASE_W-1:0] base_addr,
  output logic [PTR_W-1:0]  ring_last,
  output logic [PTR_W-1:0]  head,
  output logic              run,
  output logic              err_ie,
  output logic [1:0]        speed,
  output logic              sts_wr,
  input  logic              busy,
  input  logic [PTR_W-1:0]  tail,
  input  logic              cmp_sts,
  input  logic              err_sts
);
  localparam int HI_W = BASE_W - REG_DW;

  logic [REG_DW-1:0] base_lo_q;
  logic [HI_W-1:0]   base_hi_q;
  logic [REG_DW-1:0] retry_q;

  assign base_addr = {base_hi_q, base_lo_q};
  assign sts_wr    = wr_en && (addr == OFS_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      retry_q   <= '0;
      ring_last <= '0;
      head      <= '0;
      run       <= 1'b0;
      err_ie    <= 1'b0;
      speed     <= 2'd0;
    end else if (wr_en) begin
      case (addr)
        OFS_BASE_LO: base_lo_q <= wdata;
        OFS_BASE_HI: base_hi_q <= wdata[HI_W-1:0];
        OFS_CTRL: begin
          run    <= wdata[BIT_RUN];
          err_ie <= wdata[BIT_ERR_IE];
          head   <= wdata[PTR_LSB +: PTR_W];
        end
        OFS_SIZE:   ring_last <= wdata[PTR_W-1:0];
        OFS_RETRY:  retry_q   <= wdata;
        OFS_TIMING: speed     <= wdata[SPD_LSB +: 2];
        default: ;
      endcase
    end
  end

  logic [REG_DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_BASE_LO: rd_mux = base_lo_q;
      OFS_BASE_HI: rd_mux[HI_W-1:0] = base_hi_q;
      OFS_CTRL: begin
        rd_mux[BIT_RUN]             = run;
        rd_mux[BIT_ERR_IE]          = err_ie;
        rd_mux[PTR_LSB +: PTR_W]    = head;
      end
      OFS_STATUS: begin
        rd_mux[BIT_BUSY]            = busy;
        rd_mux[BIT_ERR_STS]         = err_sts;
        rd_mux[BIT_CMP_STS]         = cmp_sts;
        rd_mux[PTR_LSB +: PTR_W]    = tail;
      end
      OFS_SIZE:   rd_mux[PTR_W-1:0]  = ring_last;
      OFS_RETRY:  rd_mux = retry_q;
      OFS_TIMING: rd_mux[SPD_LSB +: 2] = speed;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R2: a control write takes effect on the next cycle
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_CTRL) |=> (head == $past(wdata[PTR_LSB +: PTR_W])));
endmodule

// File: rtl/ring_dispatch.sv
module ring_dispatch
  import ring_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int BASE_W     = 64,
  parameter int DESC_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PTR_W-1:0]  head,
  input  logic [PTR_W-1:0]  ring_last,
  input  logic [BASE_W-1:0] base_addr,
  input  logic              seq_done,
  output logic [PTR_W-1:0]  tail,
  output logic              busy,
  output logic              seq_start,
  output logic [PTR_W-1:0]  seq_index,
  output logic [BASE_W-1:0] seq_addr,
  output logic              fin
);
  disp_state_t state;
  logic [PTR_W-1:0]  tail_nxt;
  logic [BASE_W-1:0] offset;

  assign tail_nxt = (tail == ring_last) ? '0 : tail + 1'b1;
  assign offset   = BASE_W'(tail) << DESC_SHIFT;
  assign fin      = (state == ST_WAIT) && seq_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tail      <= '0;
      busy      <= 1'b0;
      seq_start <= 1'b0;
      seq_index <= '0;
      seq_addr  <= '0;
    end else begin
      seq_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (run && (tail != head)) begin
            seq_start <= 1'b1;
            seq_index <= tail;
            seq_addr  <= base_addr + offset;
            busy      <= 1'b1;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (seq_done) begin
            tail  <= tail_nxt;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start);
  assert_busy_on_start_R3: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> busy);
  assert_tail_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !seq_done |=> $stable(tail));
  assert_run_gate_R7: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> $past(run));
  assert_index_is_tail_R4: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> (seq_index == tail));
endmodule

// File: rtl/ring_irq.sv
module ring_irq
  import ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fin,
  input  logic              ok,
  input  logic              irq_req,
  input  logic              err_ie,
  input  logic              clr_wr,
  input  logic [REG_DW-1:0] clr_data,
  output logic              cmp_sts,
  output logic              err_sts,
  output logic              irq
);
  logic set_cmp, set_err, clr_cmp, clr_err;

  assign set_cmp = fin && irq_req;
  assign set_err = fin && !ok && err_ie;
  assign clr_cmp = clr_wr && clr_data[BIT_CMP_STS];
  assign clr_err = clr_wr && clr_data[BIT_ERR_STS];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_sts <= 1'b0;
      err_sts <= 1'b0;
    end else begin
      if (set_cmp)      cmp_sts <= 1'b1;
      else if (clr_cmp) cmp_sts <= 1'b0;
      if (set_err)      err_sts <= 1'b1;
      else if (clr_err) err_sts <= 1'b0;
    end
  end

  assign irq = cmp_sts | err_sts;

  assert_cmp_keep_R10: assert property (@(posedge clk) disable iff (rst)
    (cmp_sts && !clr_cmp) |=> cmp_sts);
  assert_err_keep_R10: assert property (@(posedge clk) disable iff (rst)
    (err_sts && !clr_err) |=> err_sts);
  assert_err_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (!err_sts && !(fin && err_ie)) |=> !err_sts);
  assert_cmp_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (!cmp_sts && !fin) |=> !cmp_sts);
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import ring_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int BASE_W     = 64,
  parameter int DESC_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              seq_start,
  output logic [PTR_W-1:0]  seq_index,
  output logic [BASE_W-1:0] seq_addr,
  input  logic              seq_done,
  input  logic              seq_ok,
  input  logic              seq_irq_req,
  output logic              busy,
  output logic              irq,
  output logic [1:0]        bus_speed
);
  logic [BASE_W-1:0] base_addr;
  logic [PTR_W-1:0]  ring_last, head, tail;
  logic run, err_ie, sts_wr, cmp_sts, err_sts, fin;

  ring_regs #(.PTR_W(PTR_W), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .base_addr(base_addr),
    .ring_last(ring_last), .head(head), .run(run), .err_ie(err_ie),
    .speed(bus_speed), .sts_wr(sts_wr), .busy(busy), .tail(tail),
    .cmp_sts(cmp_sts), .err_sts(err_sts)
  );

  ring_dispatch #(.PTR_W(PTR_W), .BASE_W(BASE_W), .DESC_SHIFT(DESC_SHIFT)) u_disp (
    .clk(clk), .rst(rst), .run(run), .head(head), .ring_last(ring_last),
    .base_addr(base_addr), .seq_done(seq_done), .tail(tail), .busy(busy),
    .seq_start(seq_start), .seq_index(seq_index), .seq_addr(seq_addr), .fin(fin)
  );

  ring_irq u_irq (
    .clk(clk), .rst(rst), .fin(fin), .ok(seq_ok), .irq_req(seq_irq_req),
    .err_ie(err_ie), .clr_wr(sts_wr), .clr_data(reg_wdata),
    .cmp_sts(cmp_sts), .err_sts(err_sts), .irq(irq)
  );

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(fin));
  assert_idle_when_caught_up_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && tail == head) |=> !seq_start);
endmodule

// File: tb/desc_ring_ctrl_bench.sv
module desc_ring_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        seq_start;
  logic [7:0]  seq_index;
  logic [63:0] seq_addr;
  logic        seq_done = 1'b0, seq_ok = 1'b0, seq_irq_req = 1'b0;
  logic        busy, irq;
  logic [1:0]  bus_speed;

  int checks = 0;
  int fails  = 0;
  int starts = 0;
  localparam logic [63:0] BASE = 64'h0000_0002_1000_0000;

  always #10 clk = ~clk;

  desc_ring_ctrl u_desc_ring_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_start(seq_start),
    .seq_index(seq_index), .seq_addr(seq_addr), .seq_done(seq_done),
    .seq_ok(seq_ok), .seq_irq_req(seq_irq_req), .busy(busy), .irq(irq),
    .bus_speed(bus_speed)
  );

  always @(negedge clk) if (!rst && seq_start) starts++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_start(input string req, input logic [7:0] idx, input logic [63:0] adr);
    int guard = 0;
    while (!seq_start && guard < 50) begin @(negedge clk); guard++; end
    chk({req, " start seen"}, seq_start, 1'b1);
    chk({req, " index"}, seq_index, idx);
    chk("R4 address", seq_addr, adr);
    chk("R3 busy", busy, 1'b1);
    @(negedge clk);
    chk("R3 single pulse", seq_start, 1'b0);
  endtask

  task automatic finish(input logic ok, input logic irqf);
    @(negedge clk); seq_done = 1'b1; seq_ok = ok; seq_irq_req = irqf;
    @(negedge clk); seq_done = 1'b0; seq_ok = 1'b0; seq_irq_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 busy", busy, 0); chk("R1 irq", irq, 0); chk("R1 seq_start", seq_start, 0);
    rd(12'h108, d); chk("R1 control", d, 0);
    rd(12'h10C, d); chk("R1 status", d, 0);
    rd(12'h110, d); chk("R1 size", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(12'h100, BASE[31:0]); wr(12'h104, BASE[63:32]);
    wr(12'h110, 32'h0000_0003); wr(12'h114, 32'hA5A5_5A5A);
    wr(12'h108, 32'hFFAB_FF10);
    rd(12'h100, d); chk("R2 base low", d, BASE[31:0]);
    rd(12'h104, d); chk("R2 base high", d, BASE[63:32]);
    rd(12'h110, d); chk("R2 size", d, 32'h3);
    rd(12'h114, d); chk("R2 retry", d, 32'hA5A5_5A5A);
    rd(12'h108, d); chk("R2 control", d, 32'h00AB_0010);
    chk("R6 no start without run", starts, 0);
    wr(12'h108, 32'h0000_0010);
  endtask

  task automatic t_dispatch();
    logic [31:0] d;
    wr(12'h108, 32'h0002_0011);
    expect_start("R3", 8'd0, BASE);
    finish(1'b1, 1'b1);
    expect_start("R3", 8'd1, BASE + 64'h10);
    finish(1'b1, 1'b0);
    idle(6);
    chk("R6 busy low at head", busy, 0);
    chk("R6 start count", starts, 2);
    rd(12'h10C, d); chk("R8 R11 status after run", d, 32'h0002_0020);
    chk("R10 irq set", irq, 1);
    wr(12'h10C, 32'h0); rd(12'h10C, d); chk("R10 zero write keeps", d, 32'h0002_0020);
    wr(12'h10C, 32'h20); rd(12'h10C, d); chk("R10 one clears", d, 32'h0002_0000);
    chk("R10 irq cleared", irq, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(12'h108, 32'h0001_0011);
    expect_start("R5", 8'd2, BASE + 64'h20); finish(1'b1, 1'b0);
    expect_start("R5", 8'd3, BASE + 64'h30); finish(1'b1, 1'b0);
    expect_start("R5 wrap", 8'd0, BASE);     finish(1'b1, 1'b0);
    idle(6);
    chk("R6 start count after wrap", starts, 5);
    rd(12'h10C, d); chk("R5 tail after wrap", d, 32'h0001_0000);
    chk("R8 no completion without request", irq, 0);
  endtask

  task automatic t_error();
    logic [31:0] d;
    wr(12'h108, 32'h0002_0011);
    expect_start("R9", 8'd1, BASE + 64'h10); finish(1'b0, 1'b0);
    idle(2);
    rd(12'h10C, d); chk("R9 error set", d, 32'h0002_0010);
    chk("R10 irq on error", irq, 1);
    wr(12'h10C, 32'h10); rd(12'h10C, d); chk("R10 error cleared", d, 32'h0002_0000);
    wr(12'h108, 32'h0003_0001);
    expect_start("R9", 8'd2, BASE + 64'h20); finish(1'b0, 1'b0);
    idle(2);
    rd(12'h10C, d); chk("R9 error masked", d, 32'h0003_0000);
    chk("R9 irq stays low", irq, 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(12'h108, 32'h0001_0001);
    expect_start("R7", 8'd3, BASE + 64'h30);
    wr(12'h108, 32'h0001_0000);
    chk("R7 busy in flight", busy, 1);
    finish(1'b1, 1'b0);
    idle(10);
    chk("R7 no further start", starts, 8);
    rd(12'h10C, d); chk("R7 tail advanced, idle", d, 32'h0000_0000);
  endtask

  task automatic t_speed();
    logic [31:0] d;
    wr(12'h300, 32'hFFFF_FFFF); rd(12'h300, d);
    chk("R12 speed readback", d, 32'hC000_0000);
    chk("R12 speed 1 MHz", bus_speed, 2'd3);
    wr(12'h300, 32'h4000_0000);
    chk("R12 speed 100 kHz", bus_speed, 2'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_dispatch();
    t_wrap();
    t_error();
    t_stop();
    t_speed();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule